// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Controller

This block sits beside the decode stage of a five-stage in-order pipeline in which a conditional branch is settled early. An equality comparator and a target adder are placed in decode, so a taken branch loses only the single instruction already fetched behind it. The block checks the branch's two source registers against the destinations of the instructions now in execute, memory and write-back. For each compare operand it picks one of three sources: the register file, the ALU result held in the memory stage, or the value being written back. When the needed value does not exist yet, it raises a stall instead.

The outcome of a stall depends on how far away the producer is and what kind of instruction it is. An ALU result one instruction ahead costs one bubble. A load two instructions ahead also costs one bubble. A load directly ahead costs two bubbles, because it waits one cycle in execute and then one cycle in memory. While stalled, the branch stays in decode and the block evaluates it again on each cycle. Once the branch is free of hazards and the compare succeeds, the block flushes the IF/ID register and signals the PC to load the computed target.

The block is purely combinational. All hazard, forward, stall and flush outputs are valid in the same cycle as their inputs. Every pin is a plain control or data signal, and there is no handshake.

Top module: `bhz_decode_ctrl`

## Requirements
- R1: When `id_branch` is 1 and there is no stall, `ifid_flush` is 1 exactly when the compare holds on the selected operands. `id_br_ne` = 0 means the compare holds when the operands are equal; `id_br_ne` = 1 means it holds when they differ.
- R2: `br_target` always equals `id_pc_plus4` plus the sign-extended `id_imm` shifted left by two bits. It is output whether or not a branch is present.
- R3: Stall case one: a branch source matches `ex_dst` while `ex_wr` is 1. `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 together.
- R4: Stall case two: a branch source matches `mem_dst` while `mem_wr` and `mem_load` are both 1. The three stall outputs are 1. The forward select for that source is 0 (register file).
- R5: Forward from memory: a source matches `mem_dst`, `mem_wr` is 1 and `mem_load` is 0. The select for that source is 1 and the operand is `mem_alu_val`. There is no stall from that source.
- R6: Forward from write-back: a source matches `wb_dst`, `wb_wr` is 1 and there is no memory-stage match. The select is 2 and the operand is `wb_val`. When both the memory and write-back stages match with an ALU result in memory, the memory stage wins (select 1).
- R7: A destination of register 0, or a destination whose write-enable is 0, never produces a stall or a non-zero forward select.
- R8: While any stall output is 1, `ifid_flush` is 0 even if the compare would hold.
- R9: With `id_branch` at 0, all stall outputs and `ifid_flush` are 0, whatever the hazards are.
- R10: A branch that reads the destination of a load directly ahead of it stalls on two successive cycles: first with the load in execute, then with the load in memory. On the third cycle it takes the value through select 2 with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_branch | input | 1 | Decode holds a conditional branch |
| id_br_ne | input | 1 | 0: branch if equal, 1: branch if not equal |
| id_rs | input | 5 | First compare source register |
| id_rt | input | 5 | Second compare source register |
| id_pc_plus4 | input | 32 | Address after the branch |
| id_imm | input | 16 | Word offset of the branch |
| rf_rs_val | input | 32 | Register file value for id_rs |
| rf_rt_val | input | 32 | Register file value for id_rt |
| ex_dst | input | 5 | Destination of the instruction in execute |
| ex_wr | input | 1 | Instruction in execute writes a register |
| mem_dst | input | 5 | Destination of the instruction in memory |
| mem_wr | input | 1 | Instruction in memory writes a register |
| mem_load | input | 1 | Instruction in memory is a load |
| mem_alu_val | input | 32 | ALU result held in the memory stage |
| wb_dst | input | 5 | Destination of the instruction in write-back |
| wb_wr | input | 1 | Instruction in write-back writes a register |
| wb_val | input | 32 | Value being written back |
| fwd_rs_sel | output | 2 | Source for id_rs: 0 file, 1 memory, 2 write-back |
| fwd_rt_sel | output | 2 | Source for id_rt: same coding |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble | output | 1 | Zero the controls entering ID/EX |
| ifid_flush | output | 1 | Branch taken: zero IF/ID, PC loads br_target |
| br_target | output | 32 | Computed branch target |

## Verification
A vector table applies each producer position to the branch sources: execute, memory as ALU, memory as load, and write-back. It also applies the two compare kinds with equal and unequal operands. Stall cases are separated from forward cases, and the memory path is separated from the write-back path. Rows with register 0 and with disabled write-enables show that a matching number alone has no effect. A row in which memory and write-back both match shows that the newer value is chosen. Directed tests cover idle inputs, targets with positive and negative offsets, and the three-cycle sequence behind a load directly ahead of the branch.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/bhz_src_check.sv
// Hazard check for one compare source: stall request, forward select, operand mux.
module bhz_src_check
  import bhz_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic          need_stall,
  output fwd_sel_e      sel,
  output logic [DW-1:0] operand
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic hit_ex, hit_mem, hit_wb;

  assign hit_ex  = ex_wr  && (ex_dst  != ZERO_REG) && (ex_dst  == src);
  assign hit_mem = mem_wr && (mem_dst != ZERO_REG) && (mem_dst == src);
  assign hit_wb  = wb_wr  && (wb_dst  != ZERO_REG) && (wb_dst  == src);

  // Value not yet available: ALU result still in execute, or load still in memory.
  assign need_stall = hit_ex || (hit_mem && mem_load);

  // Newest producer wins; a load in memory blocks the older write-back path.
  always_comb begin
    if (hit_mem) begin
      sel = mem_load ? FWD_RF : FWD_MEM;
    end else if (hit_wb) begin
      sel = FWD_WB;
    end else begin
      sel = FWD_RF;
    end
  end

  always_comb begin
    unique case (sel)
      FWD_MEM: operand = mem_val;
      FWD_WB:  operand = wb_val;
      default: operand = rf_val;
    endcase
  end

  // Forwarding from memory is never chosen for a load
  always_comb begin
    if (sel == FWD_MEM) begin
      assert_no_load_fwd_R4: assert (!mem_load && mem_wr);
    end
  end

  // Register 0 never drives a stall or a forward
  always_comb begin
    if (src == ZERO_REG) begin
      assert_zero_reg_quiet_R7: assert (!need_stall && sel == FWD_RF);
    end
  end

  // The write-back path is taken only when write-back really writes this source
  always_comb begin
    if (sel == FWD_WB) begin
      assert_wb_fwd_valid_R6: assert (wb_wr && wb_dst == src);
    end
  end
endmodule

// File: rtl/bhz_branch_eval.sv
// Decode-stage comparator and target adder.
module bhz_branch_eval #(
  parameter int DW    = 32,
  parameter int PC_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic             is_branch,
  input  logic             is_ne,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [PC_W-1:0]  pc_plus4,
  input  logic [IMM_W-1:0] imm,
  output logic             cond_true,
  output logic [PC_W-1:0]  target
);
  localparam int EXT_W = PC_W - IMM_W - 2;

  logic            same;
  logic [PC_W-1:0] offset;

  assign same      = (opa == opb);
  assign cond_true = is_branch && (is_ne ? !same : same);

  generate
    if (EXT_W > 0) begin : g_ext
      assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    end else begin : g_trunc
      assign offset = PC_W'({imm, 2'b00});
    end
  endgenerate

  assign target = pc_plus4 + offset;

  always_comb begin
    if (!is_branch) begin
      assert_no_cond_idle_R9: assert (!cond_true);
    end
  end
endmodule

// File: rtl/bhz_decode_ctrl.sv
// Top: per-source hazard checks, comparator, stall and flush control.
module bhz_decode_ctrl
  import bhz_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PC_W  = 32,
  parameter int IMM_W = 16
) (
  input  logic             id_branch,
  input  logic             id_br_ne,
  input  logic [AW-1:0]    id_rs,
  input  logic [AW-1:0]    id_rt,
  input  logic [PC_W-1:0]  id_pc_plus4,
  input  logic [IMM_W-1:0] id_imm,
  input  logic [DW-1:0]    rf_rs_val,
  input  logic [DW-1:0]    rf_rt_val,
  input  logic [AW-1:0]    ex_dst,
  input  logic             ex_wr,
  input  logic [AW-1:0]    mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [DW-1:0]    mem_alu_val,
  input  logic [AW-1:0]    wb_dst,
  input  logic             wb_wr,
  input  logic [DW-1:0]    wb_val,
  output logic [1:0]       fwd_rs_sel,
  output logic [1:0]       fwd_rt_sel,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble,
  output logic             ifid_flush,
  output logic [PC_W-1:0]  br_target
);
  localparam int NSRC = 2;

  logic [AW-1:0] src_num [NSRC];
  logic [DW-1:0] src_rf  [NSRC];
  logic [DW-1:0] src_op  [NSRC];
  fwd_sel_e      src_sel [NSRC];
  logic [NSRC-1:0] src_stall;

  assign src_num[0] = id_rs;
  assign src_num[1] = id_rt;
  assign src_rf[0]  = rf_rs_val;
  assign src_rf[1]  = rf_rt_val;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      bhz_src_check #(.AW(AW), .DW(DW)) u_chk (
        .src        (src_num[i]),
        .ex_dst     (ex_dst),
        .ex_wr      (ex_wr),
        .mem_dst    (mem_dst),
        .mem_wr     (mem_wr),
        .mem_load   (mem_load),
        .wb_dst     (wb_dst),
        .wb_wr      (wb_wr),
        .rf_val     (src_rf[i]),
        .mem_val    (mem_alu_val),
        .wb_val     (wb_val),
        .need_stall (src_stall[i]),
        .sel        (src_sel[i]),
        .operand    (src_op[i])
      );
    end
  endgenerate

  logic cond_true;
  logic stall;

  bhz_branch_eval #(.DW(DW), .PC_W(PC_W), .IMM_W(IMM_W)) u_eval (
    .is_branch (id_branch),
    .is_ne     (id_br_ne),
    .opa       (src_op[0]),
    .opb       (src_op[1]),
    .pc_plus4  (id_pc_plus4),
    .imm       (id_imm),
    .cond_true (cond_true),
    .target    (br_target)
  );

  assign stall       = id_branch && (|src_stall);
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  // Outcome is only acted upon once all operands are ready.
  assign ifid_flush  = cond_true && !stall;

  assign fwd_rs_sel = src_sel[0];
  assign fwd_rt_sel = src_sel[1];

  always_comb begin
    if (pc_hold) begin
      assert_no_flush_in_stall_R8: assert (!ifid_flush);
    end
  end

  always_comb begin
    if (ifid_flush) begin
      assert_flush_needs_branch_R1: assert (id_branch && !pc_hold);
    end
  end

  always_comb begin
    if (!id_branch) begin
      assert_idle_quiet_R9: assert (!pc_hold && !ifid_flush);
    end
  end

  always_comb begin
    if (ex_wr && ex_dst != '0 && id_branch && (ex_dst == id_rs || ex_dst == id_rt)) begin
      assert_ex_producer_stalls_R3: assert (pc_hold && ifid_hold && idex_bubble);
    end
  end
endmodule

// File: tb/bhz_decode_ctrl_test.sv
module bhz_decode_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        id_branch, id_br_ne;
  logic [4:0]  id_rs, id_rt, ex_dst, mem_dst, wb_dst;
  logic [31:0] id_pc_plus4, rf_rs_val, rf_rt_val, mem_alu_val, wb_val, br_target;
  logic [15:0] id_imm;
  logic        ex_wr, mem_wr, mem_load, wb_wr;
  logic [1:0]  fwd_rs_sel, fwd_rt_sel;
  logic        pc_hold, ifid_hold, idex_bubble, ifid_flush;

  bhz_decode_ctrl uut (
    .id_branch(id_branch), .id_br_ne(id_br_ne), .id_rs(id_rs), .id_rt(id_rt),
    .id_pc_plus4(id_pc_plus4), .id_imm(id_imm), .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .mem_alu_val(mem_alu_val), .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_val(wb_val),
    .fwd_rs_sel(fwd_rs_sel), .fwd_rt_sel(fwd_rt_sel), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush), .br_target(br_target)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic       br;  logic ne;
    logic [4:0] rs;  logic [4:0] rt;
    logic [4:0] exd; logic exw;
    logic [4:0] memd; logic memw; logic meml;
    logic [4:0] wbd; logic wbw;
    logic [7:0] rfa; logic [7:0] rfb; logic [7:0] memv; logic [7:0] wbv;
    logic       e_stall; logic [1:0] e_sa; logic [1:0] e_sb; logic e_flush;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // br ne rs rt exd exw memd memw meml wbd wbw rfa rfb memv wbv | stall sa sb flush | req
    '{1'b0,1'b0,5'd3,5'd4, 5'd3,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd1,8'd1,8'd0,8'd0, 1'b0,2'd0,2'd0,1'b0, 4'd9},
    '{1'b1,1'b0,5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd5,8'd5,8'd0,8'd0, 1'b0,2'd0,2'd0,1'b1, 4'd1},
    '{1'b1,1'b0,5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd5,8'd6,8'd0,8'd0, 1'b0,2'd0,2'd0,1'b0, 4'd1},
    '{1'b1,1'b1,5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd5,8'd6,8'd0,8'd0, 1'b0,2'd0,2'd0,1'b1, 4'd1},
    '{1'b1,1'b0,5'd1,5'd2, 5'd2,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 8'd5,8'd5,8'd0,8'd0, 1'b1,2'd0,2'd0,1'b0, 4'd3},
    '{1'b1,1'b0,5'd1,5'd2, 5'd0,1'b0, 5'd1,1'b1,1'b1, 5'd0,1'b0, 8'd5,8'd5,8'd0,8'd0, 1'b1,2'd0,2'd0,1'b0, 4'd4},
    '{1'b1,1'b0,5'd1,5'd2, 5'd0,1'b0, 5'd1,1'b1,1'b0, 5'd0,1'b0, 8'd0,8'd9,8'd9,8'd0, 1'b0,2'd1,2'd0,1'b1, 4'd5},
    '{1'b1,1'b0,5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 5'd2,1'b1, 8'd7,8'd0,8'd0,8'd7, 1'b0,2'd0,2'd2,1'b1, 4'd6},
    '{1'b1,1'b0,5'd4,5'd4, 5'd0,1'b0, 5'd4,1'b1,1'b0, 5'd4,1'b1, 8'd0,8'd0,8'd3,8'd8, 1'b0,2'd1,2'd1,1'b1, 4'd6},
    '{1'b1,1'b0,5'd0,5'd0, 5'd0,1'b1, 5'd0,1'b1,1'b1, 5'd0,1'b1, 8'd0,8'd0,8'd3,8'd8, 1'b0,2'd0,2'd0,1'b1, 4'd7},
    '{1'b1,1'b0,5'd3,5'd6, 5'd3,1'b0, 5'd3,1'b0,1'b0, 5'd6,1'b0, 8'd1,8'd1,8'd2,8'd2, 1'b0,2'd0,2'd0,1'b1, 4'd7},
    '{1'b1,1'b1,5'd1,5'd2, 5'd0,1'b0, 5'd2,1'b1,1'b0, 5'd0,1'b0, 8'd4,8'd0,8'd4,8'd0, 1'b0,2'd0,2'd1,1'b0, 4'd5}
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    id_branch = 0; id_br_ne = 0; id_rs = 0; id_rt = 0; id_pc_plus4 = 0; id_imm = 0;
    rf_rs_val = 0; rf_rt_val = 0; ex_dst = 0; ex_wr = 0; mem_dst = 0; mem_wr = 0;
    mem_load = 0; mem_alu_val = 0; wb_dst = 0; wb_wr = 0; wb_val = 0;
  endtask

  task automatic check_ctrl(input string tag, input logic stall, input logic [1:0] sa,
                            input logic [1:0] sb, input logic flush);
    check(tag, "stall", {29'd0, pc_hold, ifid_hold, idex_bubble}, {29'd0, {3{stall}}});
    check(tag, "rs_sel", {30'd0, fwd_rs_sel}, {30'd0, sa});
    check(tag, "rt_sel", {30'd0, fwd_rt_sel}, {30'd0, sb});
    check(tag, "flush", {31'd0, ifid_flush}, {31'd0, flush});
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    // Idle state with all inputs zero (R9)
    check_ctrl("R9", 1'b0, 2'd0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      id_branch = VEC[i].br; id_br_ne = VEC[i].ne; id_rs = VEC[i].rs; id_rt = VEC[i].rt;
      ex_dst = VEC[i].exd; ex_wr = VEC[i].exw;
      mem_dst = VEC[i].memd; mem_wr = VEC[i].memw; mem_load = VEC[i].meml;
      wb_dst = VEC[i].wbd; wb_wr = VEC[i].wbw;
      rf_rs_val = {24'd0, VEC[i].rfa}; rf_rt_val = {24'd0, VEC[i].rfb};
      mem_alu_val = {24'd0, VEC[i].memv}; wb_val = {24'd0, VEC[i].wbv};
      #5;
      check($sformatf("R%0d/vec%0d", VEC[i].req, i), "stall", {29'd0, pc_hold, ifid_hold, idex_bubble},
            {29'd0, {3{VEC[i].e_stall}}});
      check($sformatf("R%0d/vec%0d", VEC[i].req, i), "rs_sel", {30'd0, fwd_rs_sel}, {30'd0, VEC[i].e_sa});
      check($sformatf("R%0d/vec%0d", VEC[i].req, i), "rt_sel", {30'd0, fwd_rt_sel}, {30'd0, VEC[i].e_sb});
      check($sformatf("R%0d/vec%0d", VEC[i].req, i), "flush", {31'd0, ifid_flush}, {31'd0, VEC[i].e_flush});
    end

    // R2: target with positive and negative offsets
    @(negedge clk);
    idle_inputs();
    id_pc_plus4 = 32'h0000_0100; id_imm = 16'h0010;
    #5 check("R2", "target+", br_target, 32'h0000_0140);
    @(negedge clk);
    id_imm = 16'hFFFE;
    #5 check("R2", "target-", br_target, 32'h0000_00F8);
    @(negedge clk);
    id_pc_plus4 = 32'h0000_0004; id_imm = 16'h8000;
    #5 check("R2", "target_min", br_target, 32'hFFFE_0004);

    // R10: load directly ahead of a branch on r5
    @(negedge clk);
    idle_inputs();
    id_branch = 1; id_rs = 5'd5; id_rt = 5'd6; rf_rt_val = 32'd11; rf_rs_val = 32'd0;
    ex_dst = 5'd5; ex_wr = 1;
    #5 check_ctrl("R10_c1", 1'b1, 2'd0, 2'd0, 1'b0);
    @(negedge clk);
    ex_dst = 0; ex_wr = 0;
    mem_dst = 5'd5; mem_wr = 1; mem_load = 1;
    #5 check_ctrl("R10_c2", 1'b1, 2'd0, 2'd0, 1'b0);
    @(negedge clk);
    mem_dst = 0; mem_wr = 0; mem_load = 0;
    wb_dst = 5'd5; wb_wr = 1; wb_val = 32'd11;
    #5 check_ctrl("R10_c3", 1'b0, 2'd2, 2'd0, 1'b1);

    // R8: a compare that holds while the second source is still in execute
    @(negedge clk);
    idle_inputs();
    id_branch = 1; id_br_ne = 1; id_rs = 5'd7; id_rt = 5'd8; rf_rs_val = 1; rf_rt_val = 2;
    ex_dst = 5'd8; ex_wr = 1;
    #5 check_ctrl("R8", 1'b1, 2'd0, 2'd0, 1'b0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule